// File: doc/BRIEF.md
# Package Sleep State Controller

This block steps a processor package through its low-power states: Normal, Stop-Grant, Stop-Grant Snoop and Sleep. It runs on the bus clock. It watches an active-low stop-clock request, an active-low sleep request, a pulse that marks the response phase of the stop-grant acknowledge cycle, and a pair of snoop start and snoop done strobes. Five asynchronous wake events are synchronised inside the block. These are system-management interrupt, init, bus-init and two local interrupt lines. While the package is stopped they are collapsed into one flag each.

When the package returns to Normal, the collected flags are handed out for exactly one cycle as a service vector and then wiped. While stopped, an active-low pending-break output tells system logic that some event is waiting. Illegal uses of the sleep request, and activity on the other inputs during Sleep, raise a one-cycle violation pulse. The bus protocol engine that produces the acknowledge and snoop strobes sits outside this block.

The internal states are Normal, Entry countdown, Stop-Grant, Snoop and Sleep. The transitions are:
- Normal to Entry: an acknowledge pulse arrives with stop requested.
- Entry to Normal: stop is released during the countdown.
- Entry to Stop-Grant: the count expires.
- Stop-Grant to Sleep: the sleep request is asserted.
- Stop-Grant to Snoop: a snoop starts.
- Stop-Grant to Normal: stop is released.
- Snoop to Stop-Grant: the snoop is done.
- Sleep to Stop-Grant: the sleep request is released.
- Device reset: Stop-Grant or Snoop goes to Stop-Grant. Every other state goes to Normal.

Top module: `pkg_sleep_ctrl`

## Requirements
- R1: After power-on reset, `state_o` is 00, the latched flags and service vector are 0, `pend_break_n_o` is 1 and `viol_o` is 0. The state codes are 00 Normal (this includes the entry countdown), 01 Stop-Grant, 10 Snoop and 11 Sleep.
- R2: The acknowledge pulse is sampled on a clock edge with `stop_clk_n_i` low. `state_o` reads 01 starting exactly 20 edges later, and reads 00 on the cycle before.
- R3: Releasing `stop_clk_n_i` during the countdown aborts it. An acknowledge pulse with `stop_clk_n_i` high is ignored. Either way the state stays 00, and a later entry needs a fresh acknowledge and a full 20-clock count.
- R4: In Stop-Grant, `snoop_start_i` moves the state to 10 on the next edge. In Snoop, `snoop_done_i` returns it to 01 on the next edge.
- R5: Sleep (11) is entered only from Stop-Grant, when `sleep_n_i` is low. A low `sleep_n_i` in Normal, Entry or Snoop leaves the state unchanged and raises `viol_o` on the next cycle.
- R6: In Sleep, a high `sleep_n_i` returns the state to 01. A high `stop_clk_n_i` seen while still in Sleep raises `viol_o` on the next cycle.
- R7: In Sleep, any of `grant_ack_i`, `snoop_start_i`, `snoop_done_i` or a synchronised wake event raises `viol_o`. Wake events are not latched in Sleep.
- R8: In Stop-Grant and Snoop, each synchronised wake event sets its own flag, and repeated occurrences leave a single flag. The bit positions are 0 system-management interrupt, 1 init, 2 bus-init, 3 local interrupt 0 and 4 local interrupt 1.
- R9: `pend_break_n_o` is 0 exactly when the state is 01 or 10 and at least one flag is set.
- R10: On the edge that returns Stop-Grant to Normal, `evt_service_o` takes the flags for one cycle and the flags clear.
- R11: A low `rst_n_i` clears the flags. In Stop-Grant or Snoop the state becomes 01. In Sleep or any other state it becomes 00.
- R12: In Stop-Grant, a high `stop_clk_n_i` with no sleep or snoop request returns the state to 00 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| rst_n_i | input | 1 | Synchronous device reset, active low |
| stop_clk_n_i | input | 1 | Stop-clock request, active low |
| sleep_n_i | input | 1 | Sleep request, active low |
| grant_ack_i | input | 1 | Response-phase pulse of the stop-grant acknowledge |
| snoop_start_i | input | 1 | Snoop transaction begins |
| snoop_done_i | input | 1 | Snoop transaction serviced |
| wake_evt_i | input | 5 | Asynchronous wake events |
| state_o | output | 2 | Package state code |
| evt_latched_o | output | 5 | Collapsed wake-event flags |
| evt_service_o | output | 5 | One-cycle service vector on return to Normal |
| pend_break_n_o | output | 1 | Pending break, active low |
| viol_o | output | 1 | Protocol violation pulse |

## Verification
Two pairs of functions can land in the same cycle, and the bench forces each pair together.

The first pair is leaving Sleep and the early-release check. The bench raises the sleep request and the stop-clock request on one and the same edge. It then expects the violation pulse together with the move to Stop-Grant, and Normal on the following edge. It contrasts this with the legal order, where stop is released one clock after sleep and no pulse appears.

The second pair is releasing the flags and handing them to service. On the edge of the return to Normal, the scoreboard expects the service vector to hold the old flags while the flags themselves already read zero.

// File: rtl/pkg_sleep_ctrl_pkg.sv
package pkg_sleep_ctrl_pkg;

    localparam int EVT_W = 5;
    localparam int EVT_SMI   = 0;
    localparam int EVT_INIT  = 1;
    localparam int EVT_BINIT = 2;
    localparam int EVT_LINT0 = 3;
    localparam int EVT_LINT1 = 4;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_ENTRY,
        ST_GRANT,
        ST_SNOOP,
        ST_SLEEP
    } pstate_t;

    localparam logic [1:0] CODE_NORMAL = 2'b00;
    localparam logic [1:0] CODE_GRANT  = 2'b01;
    localparam logic [1:0] CODE_SNOOP  = 2'b10;
    localparam logic [1:0] CODE_SLEEP  = 2'b11;

    function automatic logic [1:0] code_of(input pstate_t s);
        unique case (s)
            ST_GRANT: code_of = CODE_GRANT;
            ST_SNOOP: code_of = CODE_SNOOP;
            ST_SLEEP: code_of = CODE_SLEEP;
            default:  code_of = CODE_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/pss_entry_timer.sv
module pss_entry_timer #(
    parameter int DELAY = 20
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic load_i,
    input  logic clear_i,
    output logic expired_o
);
    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pss_event_latch.sv
module pss_event_latch #(
    parameter int N    = 5,
    parameter int SYNC = 2
) (
    input  logic         clk_i,
    input  logic         por_n_i,
    input  logic [N-1:0] evt_async_i,
    input  logic         capture_i,
    input  logic         release_i,
    input  logic         flush_i,
    output logic [N-1:0] evt_seen_o,
    output logic [N-1:0] latched_o,
    output logic [N-1:0] service_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_sync
            logic [SYNC-1:0] chain_q;
            always_ff @(posedge clk_i or negedge por_n_i) begin
                if (!por_n_i) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[SYNC-2:0], evt_async_i[g]};
                end
            end
            assign evt_seen_o[g] = chain_q[SYNC-1];
        end
    endgenerate

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            latched_o <= '0;
            service_o <= '0;
        end else begin
            service_o <= '0;
            if (flush_i) begin
                latched_o <= '0;
            end else if (release_i) begin
                service_o <= latched_o;
                latched_o <= '0;
            end else if (capture_i) begin
                latched_o <= latched_o | evt_seen_o;
            end
        end
    end
endmodule

// File: rtl/pkg_sleep_ctrl.sv
module pkg_sleep_ctrl
    import pkg_sleep_ctrl_pkg::*;
#(
    parameter int ENTRY_DELAY = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic             rst_n_i,
    input  logic             stop_clk_n_i,
    input  logic             sleep_n_i,
    input  logic             grant_ack_i,
    input  logic             snoop_start_i,
    input  logic             snoop_done_i,
    input  logic [EVT_W-1:0] wake_evt_i,
    output logic [1:0]       state_o,
    output logic [EVT_W-1:0] evt_latched_o,
    output logic [EVT_W-1:0] evt_service_o,
    output logic             pend_break_n_o,
    output logic             viol_o
);
    pstate_t cur_q, nxt;
    logic load, clr, capture, release_evt, flush, expired, viol_now;
    logic [EVT_W-1:0] seen;

    pss_entry_timer #(.DELAY(ENTRY_DELAY)) u_timer (
        .clk_i     (clk_i),
        .por_n_i   (por_n_i),
        .load_i    (load),
        .clear_i   (clr),
        .expired_o (expired)
    );

    pss_event_latch #(.N(EVT_W), .SYNC(SYNC_STAGES)) u_events (
        .clk_i       (clk_i),
        .por_n_i     (por_n_i),
        .evt_async_i (wake_evt_i),
        .capture_i   (capture),
        .release_i   (release_evt),
        .flush_i     (flush),
        .evt_seen_o  (seen),
        .latched_o   (evt_latched_o),
        .service_o   (evt_service_o)
    );

    // State register
    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) cur_q <= ST_NORMAL;
        else          cur_q <= nxt;
    end

    // Next state and control strobes
    always_comb begin
        nxt         = cur_q;
        load        = 1'b0;
        clr         = 1'b0;
        capture     = 1'b0;
        release_evt = 1'b0;
        flush       = 1'b0;
        unique case (cur_q)
            ST_NORMAL: begin
                if (!stop_clk_n_i && grant_ack_i) begin
                    nxt  = ST_ENTRY;
                    load = 1'b1;
                end
            end
            ST_ENTRY: begin
                if (stop_clk_n_i) begin
                    nxt = ST_NORMAL;
                    clr = 1'b1;
                end else if (expired) begin
                    nxt = ST_GRANT;
                end
            end
            ST_GRANT: begin
                capture = 1'b1;
                if (!sleep_n_i) begin
                    nxt = ST_SLEEP;
                end else if (snoop_start_i) begin
                    nxt = ST_SNOOP;
                end else if (stop_clk_n_i) begin
                    nxt         = ST_NORMAL;
                    release_evt = 1'b1;
                end
            end
            ST_SNOOP: begin
                capture = 1'b1;
                if (snoop_done_i) nxt = ST_GRANT;
            end
            ST_SLEEP: begin
                if (sleep_n_i) nxt = ST_GRANT;
            end
            default: nxt = ST_NORMAL;
        endcase
        if (!rst_n_i) begin
            flush       = 1'b1;
            clr         = 1'b1;
            load        = 1'b0;
            capture     = 1'b0;
            release_evt = 1'b0;
            nxt = (cur_q == ST_GRANT || cur_q == ST_SNOOP) ? ST_GRANT : ST_NORMAL;
        end
    end

    // Violation detection
    always_comb begin
        viol_now = 1'b0;
        if (!sleep_n_i && !(cur_q == ST_GRANT || cur_q == ST_SLEEP)) viol_now = 1'b1;
        if (cur_q == ST_SLEEP &&
            (stop_clk_n_i || grant_ack_i || snoop_start_i || snoop_done_i || (|seen)))
            viol_now = 1'b1;
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i)     viol_o <= 1'b0;
        else if (!rst_n_i) viol_o <= 1'b0;
        else              viol_o <= viol_now;
    end

    // Outputs
    always_comb begin
        state_o        = code_of(cur_q);
        pend_break_n_o = !((cur_q == ST_GRANT || cur_q == ST_SNOOP) && (|evt_latched_o));
    end
endmodule

// File: rtl/pss_checker.sv
module pss_checker (
    input logic       clk_i,
    input logic       por_n_i,
    input logic       rst_n_i,
    input logic       stop_clk_n_i,
    input logic [1:0] state_o,
    input logic [4:0] evt_latched_o,
    input logic [4:0] evt_service_o,
    input logic       pend_break_n_o,
    input logic       viol_o
);
    p_grant_entry_r2: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (state_o == 2'b01 && $past(state_o) == 2'b00) |-> !$past(stop_clk_n_i));

    p_sleep_from_grant_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (state_o == 2'b11 && $past(state_o) != 2'b11) |-> $past(state_o) == 2'b01);

    p_early_release_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (state_o == 2'b11 && stop_clk_n_i && rst_n_i) |=> viol_o);

    p_latch_hold_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (state_o == 2'b01 && $past(state_o) == 2'b01 && $past(rst_n_i))
        |-> ((evt_latched_o & $past(evt_latched_o)) == $past(evt_latched_o)));

    p_break_scope_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !pend_break_n_o |-> ((state_o == 2'b01 || state_o == 2'b10) && (|evt_latched_o)));

    p_service_r10: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (|evt_service_o) |-> (state_o == 2'b00 && evt_latched_o == '0 && $past(state_o) == 2'b01));

    p_service_pulse_r10: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (|evt_service_o) |=> (evt_service_o == '0));
endmodule

bind pkg_sleep_ctrl pss_checker u_pss_checker (
    .clk_i          (clk_i),
    .por_n_i        (por_n_i),
    .rst_n_i        (rst_n_i),
    .stop_clk_n_i   (stop_clk_n_i),
    .state_o        (state_o),
    .evt_latched_o  (evt_latched_o),
    .evt_service_o  (evt_service_o),
    .pend_break_n_o (pend_break_n_o),
    .viol_o         (viol_o)
);

// File: tb/tb_pkg_sleep_ctrl.sv
module tb_pkg_sleep_ctrl;
    localparam int K_STATE = 0, K_LATCH = 1, K_SVC = 2, K_PBE = 3, K_VIOL = 4;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b1, stop_n = 1'b1, sleep_n = 1'b1;
    logic       ack = 1'b0, snp_s = 1'b0, snp_d = 1'b0;
    logic [4:0] evt = '0;
    logic [1:0] state;
    logic [4:0] latched, svc;
    logic       pbe_n, viol;

    int cur = 0, n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        int         cyc;
        int         kind;
        logic [4:0] val;
        string      req;
    } exp_t;
    exp_t q[$];
    exp_t mon_e;

    always #10 clk = ~clk;
    always @(posedge clk) cur <= cur + 1;

    pkg_sleep_ctrl dut (
        .clk_i(clk), .por_n_i(por_n), .rst_n_i(rst_n), .stop_clk_n_i(stop_n),
        .sleep_n_i(sleep_n), .grant_ack_i(ack), .snoop_start_i(snp_s),
        .snoop_done_i(snp_d), .wake_evt_i(evt), .state_o(state),
        .evt_latched_o(latched), .evt_service_o(svc), .pend_break_n_o(pbe_n),
        .viol_o(viol)
    );

    function automatic logic [4:0] actual(input int k);
        case (k)
            K_STATE: actual = {3'b000, state};
            K_LATCH: actual = latched;
            K_SVC:   actual = svc;
            K_PBE:   actual = {4'b0000, pbe_n};
            default: actual = {4'b0000, viol};
        endcase
    endfunction

    task automatic expect_at(input int d, input int k, input logic [4:0] v, input string r);
        exp_t e;
        int i;
        e.cyc = cur + d; e.kind = k; e.val = v; e.req = r;
        i = q.size();
        while (i > 0 && q[i-1].cyc > e.cyc) i--;
        q.insert(i, e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare due items
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cur) begin
            mon_e = q.pop_front();
            n_chk++;
            if (actual(mon_e.kind) !== mon_e.val) begin
                n_fail++;
                $display("FAIL %s kind=%0d cycle=%0d actual=%b expected=%b",
                         mon_e.req, mon_e.kind, cur, actual(mon_e.kind), mon_e.val);
            end
        end
    end

    task automatic enter_grant(input string r);
        stop_n = 1'b0; ack = 1'b1;
        expect_at(20, K_STATE, 5'd0, r);
        expect_at(21, K_STATE, 5'd1, r);
        tick(1); ack = 1'b0;
        tick(20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        // R1 reset state
        expect_at(1, K_STATE, 5'd0, "R1");
        expect_at(1, K_LATCH, 5'd0, "R1");
        expect_at(1, K_SVC,   5'd0, "R1");
        expect_at(1, K_PBE,   5'd1, "R1");
        expect_at(1, K_VIOL,  5'd0, "R1");
        tick(2);

        // R3: acknowledge ignored without stop request
        ack = 1'b1;
        expect_at(1, K_STATE, 5'd0, "R3");
        expect_at(25, K_STATE, 5'd0, "R3");
        tick(1); ack = 1'b0; tick(26);

        // R2: exact entry delay
        enter_grant("R2");

        // R8/R9: events collapsed while stopped
        evt[0] = 1'b1; tick(2); evt[0] = 1'b0; tick(2);
        evt[0] = 1'b1; tick(2); evt[0] = 1'b0;
        evt[3] = 1'b1; tick(2); evt[3] = 1'b0; tick(4);
        expect_at(1, K_LATCH, 5'b01001, "R8");
        expect_at(1, K_PBE,   5'd0,     "R9");
        tick(1);

        // R4: snoop round trip
        snp_s = 1'b1;
        expect_at(1, K_STATE, 5'd2, "R4");
        expect_at(1, K_PBE,   5'd0, "R9");
        tick(1); snp_s = 1'b0; tick(2);
        snp_d = 1'b1;
        expect_at(1, K_STATE, 5'd1, "R4");
        tick(1); snp_d = 1'b0; tick(1);

        // R12/R10: release stop, service vector for one cycle
        stop_n = 1'b1;
        expect_at(1, K_STATE, 5'd0,     "R12");
        expect_at(1, K_SVC,   5'b01001, "R10");
        expect_at(1, K_LATCH, 5'd0,     "R10");
        expect_at(1, K_PBE,   5'd1,     "R9");
        expect_at(2, K_SVC,   5'd0,     "R10");
        tick(3);

        // R5: sleep request in Normal is a violation
        sleep_n = 1'b0;
        expect_at(1, K_VIOL,  5'd1, "R5");
        expect_at(1, K_STATE, 5'd0, "R5");
        tick(1); sleep_n = 1'b1;
        expect_at(1, K_VIOL, 5'd0, "R5");
        tick(2);

        // R3: abort countdown, no resumption, full restart
        stop_n = 1'b0; ack = 1'b1; tick(1); ack = 1'b0; tick(5);
        stop_n = 1'b1;
        expect_at(1, K_STATE, 5'd0, "R3");
        tick(2);
        stop_n = 1'b0;
        expect_at(25, K_STATE, 5'd0, "R3");
        tick(26);
        enter_grant("R3");

        // R5/R7: sleep, then forbidden activity
        sleep_n = 1'b0;
        expect_at(1, K_STATE, 5'd3, "R5");
        expect_at(1, K_VIOL,  5'd0, "R5");
        tick(2);
        snp_s = 1'b1;
        expect_at(1, K_VIOL, 5'd1, "R7");
        tick(1); snp_s = 1'b0; tick(2);
        evt[2] = 1'b1;
        expect_at(3, K_VIOL,  5'd1, "R7");
        expect_at(4, K_LATCH, 5'd0, "R7");
        tick(1); evt[2] = 1'b0; tick(5);

        // R6: legal exit order
        sleep_n = 1'b1;
        expect_at(1, K_STATE, 5'd1, "R6");
        expect_at(1, K_VIOL,  5'd0, "R6");
        tick(1); stop_n = 1'b1;
        expect_at(1, K_STATE, 5'd0, "R6");
        expect_at(1, K_VIOL,  5'd0, "R6");
        tick(3);

        // R6: simultaneous release is flagged
        enter_grant("R2");
        sleep_n = 1'b0; tick(3);
        sleep_n = 1'b1; stop_n = 1'b1;
        expect_at(1, K_VIOL,  5'd1, "R6");
        expect_at(1, K_STATE, 5'd1, "R6");
        expect_at(2, K_STATE, 5'd0, "R6");
        tick(3);

        // R11: device reset in Stop-Grant and in Sleep
        enter_grant("R2");
        evt[1] = 1'b1; tick(2); evt[1] = 1'b0; tick(4);
        expect_at(1, K_LATCH, 5'b00010, "R8");
        tick(1);
        rst_n = 1'b0;
        expect_at(1, K_STATE, 5'd1, "R11");
        expect_at(1, K_LATCH, 5'd0, "R11");
        expect_at(1, K_PBE,   5'd1, "R11");
        tick(1); rst_n = 1'b1; tick(1);
        sleep_n = 1'b0;
        expect_at(1, K_STATE, 5'd3, "R5");
        tick(2);
        rst_n = 1'b0;
        expect_at(1, K_STATE, 5'd0, "R11");
        tick(1); rst_n = 1'b1; sleep_n = 1'b1; stop_n = 1'b1;
        expect_at(2, K_STATE, 5'd0, "R11");
        tick(4);

        while (q.size() > 0) tick(1);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule